// File: doc/BRIEF.md
# Bit-Slice Data Routing Matrix

This block moves single bits from sixteen 16-bit source registers into sixteen 16-bit destination registers over one shared bus bit. The sources are arranged as two banks of eight. A 4-bit source index drives the selection. Its top bit enables one bank and its lower three bits pick the channel inside that bank. A 4-bit destination index picks the one destination register that shifts in the bus bit on that cycle.

An internal sequencer steps both indices after a start pulse. The source index steps on every transfer cycle. The source registers rotate by one bit every sixteen transfers, so each register presents its current top bit to the bus before any register presents its next one. The full sequence takes 256 transfers.

Two routing patterns are available:
- **Transpose:** the destination index follows the bit step. Bit plane k of all sources lands in destination k.
- **Pass-through:** the destination index follows the source index. Each source is copied to the destination with the same number.

Top module: `bitslice_router`

## Requirements
- R1: After reset, `busy`, `done` and `bank_en` are zero. Every source and destination register is zero.
- R2: While idle, `load` writes `load_data` into the source registers. Register i is `load_data[16*i +: 16]`. While busy, `load` is ignored. If `load` and `start` are high in the same idle cycle, the new data is captured and the new sequence routes it. While idle without `load`, the source registers hold.
- R3: During transfer t (t = 0..255), the source index is s = t mod 16.
  - `bank_en` is 2'b01 when s < 8 and 2'b10 when s >= 8. Exactly one bit is high while busy, and `bank_en` is 2'b00 while idle.
  - `chan_sel` equals s[2:0].
- R4: During transfer t, `bus_bit` equals bit (15 − t/16) of source s as it was loaded. This holds because the sources rotate left by one once every 16 transfers.
- R5: In transpose mode (`mode_pass` = 0 at start), `dst_sel` equals t/16. At the end, bit (15 − s) of destination k equals bit (15 − k) of source s.
- R6: In pass-through mode (`mode_pass` = 1 at start), `dst_sel` equals s. At the end, destination i equals source i.
- R7: The addressed destination shifts left and takes the bus bit into bit 0. All other destinations hold. Destinations do not change while idle.
- R8: `busy` rises in the cycle after an idle `start`. It stays high for exactly 256 cycles. `done` is high for exactly one cycle, in the cycle after the last transfer.
- R9: A `start` or a `mode_pass` change while busy has no effect on the running sequence.
- R10: When `done` is high, every source register again holds its loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a routing sequence (idle only) |
| mode_pass | input | 1 | Pattern select at start: 0 transpose, 1 pass-through |
| load | input | 1 | Parallel load of the source registers (idle only) |
| load_data | input | 256 | Source register values, register i in bits 16*i+15..16*i |
| busy | output | 1 | Sequence running; one transfer per cycle |
| done | output | 1 | One-cycle pulse after the last transfer |
| bank_en | output | 2 | Source bank enable, one-hot while busy |
| chan_sel | output | 3 | Channel address inside the enabled bank |
| dst_sel | output | 4 | Destination register address |
| bus_bit | output | 1 | Shared bus bit |
| src_data | output | 256 | Current source register contents |
| dst_data | output | 256 | Current destination register contents |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is parallel load and sequence start. Both are asserted in one idle cycle. The scoreboard then expects every bus bit to come from the newly loaded data and not from the previous contents.

The second pair is a running transfer and a fresh start with a new load. Partway through a sequence, `start`, `load` and a flipped `mode_pass` are pulsed together. The monitor keeps comparing each transfer against the pattern fixed at the original start. Afterwards the final destination and source contents are compared against the original data.

// File: rtl/bitslice_router.sv
module bitslice_router #(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_pass,
  input  logic             load,
  input  logic [N*N-1:0]   load_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       bank_en,
  output logic [$clog2(N)-2:0] chan_sel,
  output logic [$clog2(N)-1:0] dst_sel,
  output logic             bus_bit,
  output logic [N*N-1:0]   src_data,
  output logic [N*N-1:0]   dst_data
);
  localparam int IW   = $clog2(N);
  localparam int HALF = N / 2;
  localparam int CW   = 2 * IW;

  logic [N-1:0]    src_q [N];
  logic [N-1:0]    dst_q [N];
  logic [CW-1:0]   cnt;
  logic            mode_q;
  logic [1:0]      bank_bit;

  wire [IW-1:0] src_sel = cnt[IW-1:0];
  wire [IW-1:0] step    = cnt[CW-1:IW];
  wire          last    = (cnt == {CW{1'b1}});

  assign chan_sel = src_sel[IW-2:0];
  assign bank_en  = busy ? (src_sel[IW-1] ? 2'b10 : 2'b01) : 2'b00;
  assign dst_sel  = mode_q ? src_sel : step;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    wire [IW-1:0] idx = {b[0], chan_sel};
    assign bank_bit[b] = bank_en[b] & src_q[idx][N-1];
  end
  assign bus_bit = |bank_bit;

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign src_data[i*N +: N] = src_q[i];
    assign dst_data[i*N +: N] = dst_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      mode_q <= 1'b0;
      for (int i = 0; i < N; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load)
          for (int i = 0; i < N; i++) src_q[i] <= load_data[i*N +: N];
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          mode_q <= mode_pass;
        end
      end else begin
        dst_q[dst_sel] <= {dst_q[dst_sel][N-2:0], bus_bit};
        cnt <= cnt + 1'b1;
        if (src_sel == {IW{1'b1}})
          for (int i = 0; i < N; i++) src_q[i] <= {src_q[i][N-2:0], src_q[i][N-1]};
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(bank_en) == 1);
  assert_no_bank_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bank_en == 2'b00);
  assert_src_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(src_data));
  assert_dst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(dst_data));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> (done && !busy));
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(mode_q) && cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/bitslice_router_tb.sv
module bitslice_router_tb;
  localparam int N = 16;
  logic clk = 0, rst_n = 0, start = 0, mode_pass = 0, load = 0;
  logic [N*N-1:0] load_data = '0;
  logic busy, done, bus_bit;
  logic [1:0] bank_en;
  logic [2:0] chan_sel;
  logic [3:0] dst_sel;
  logic [N*N-1:0] src_data, dst_data;
  int total = 0, bad = 0;
  logic [9:0] exp_q [$];

  always #2 clk = ~clk;

  bitslice_router #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_pass(mode_pass), .load(load),
    .load_data(load_data), .busy(busy), .done(done), .bank_en(bank_en),
    .chan_sel(chan_sel), .dst_sel(dst_sel), .bus_bit(bus_bit),
    .src_data(src_data), .dst_data(dst_data));

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // monitor: one scoreboard item per transfer cycle
  always @(negedge clk) if (rst_n && busy) begin
    logic [9:0] got, e;
    got = {dst_sel, bank_en, chan_sel, bus_bit};
    if (exp_q.size() == 0) chk("R8 extra transfer", 256'(got), 256'h3ff);
    else begin
      e = exp_q.pop_front();
      chk("R3 R4 R5 R6 R9 transfer", 256'(got), 256'(e));
    end
  end

  task automatic run(input logic [N*N-1:0] d, input logic pass, input logic same_cycle, input logic inject);
    logic [N*N-1:0] expd;
    int cyc;
    for (int t = 0; t < 256; t++) begin
      int s, k;
      s = t % 16; k = t / 16;
      exp_q.push_back({pass ? 4'(s) : 4'(k), (s < 8) ? 2'b01 : 2'b10, 3'(s), d[s*N + 15 - k]});
    end
    @(negedge clk);
    if (!same_cycle) begin
      load = 1; load_data = d;
      @(negedge clk);
      load = 0;
      chk("R2 idle load", src_data, d);
    end else begin
      load = 1; load_data = d;
    end
    start = 1; mode_pass = pass;
    @(negedge clk);
    start = 0; load = 0;
    chk("R8 busy after start", 256'(busy), 256'(1));
    chk("R2 load with start", src_data, d);
    cyc = 1;
    while (!done && cyc < 400) begin
      if (inject && cyc == 100) begin
        start = 1; mode_pass = ~pass; load = 1; load_data = ~d;
      end else begin
        start = 0; load = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; load = 0;
    chk("R8 done timing", 256'(cyc), 256'(257));
    chk("R8 queue drained", 256'(exp_q.size()), 256'(0));
    chk("R10 sources restored", src_data, d);
    for (int k = 0; k < N; k++)
      for (int s = 0; s < N; s++)
        expd[k*N + 15 - s] = pass ? d[k*N + 15 - s] : d[s*N + 15 - k];
    chk(pass ? "R6 pass-through result" : "R5 transpose result", dst_data, expd);
    @(negedge clk);
    chk("R8 done one cycle", 256'({done, busy}), 256'(0));
    chk("R7 dst hold idle", dst_data, expd);
    exp_q.delete();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*N-1:0] a, b, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", 256'({busy, done, bank_en}), 256'(0));
    chk("R1 reset sources", src_data, '0);
    chk("R1 reset dests", dst_data, '0);
    for (int i = 0; i < N; i++) begin
      a[i*N +: N] = 16'hA5C3 ^ 16'(i * 16'h1357);
      b[i*N +: N] = 16'h0F1E + 16'(i * 16'h2469);
      w[i*N +: N] = 16'(1 << i);
    end
    run(a, 1'b0, 1'b0, 1'b1);   // transpose, mid-run start/load/mode ignored (R9, R2)
    run(b, 1'b1, 1'b1, 1'b0);   // pass-through, load and start same cycle (R2)
    run(w, 1'b0, 1'b1, 1'b0);   // transpose of a walking-one matrix
    run(a, 1'b1, 1'b0, 1'b1);   // pass-through with mid-run injection
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule